// File: doc/BRIEF.md
# Serial ROM Command Layer

This block is the device-side selection stage of a single-wire serial bus slave. A bit-level transceiver beneath it hands over received bits and takes bits to send. The layer gathers an 8-bit command, least significant bit first, and runs one of eight selection commands against a 64-bit device identity. It can send the identity, compare it against bits from the master, or take part in a bit-wise search. Only a command that finishes successfully raises the grant that opens the memory-function layer above.

The layer also holds the bus speed flag, which is standard or overdrive. It keeps a selection flag so that a later resume command can reopen access without a new addressing pass. Received bits use a valid/ready handshake, and bits sent out use a second one. The layer drops `rx_ready` while it is sending, and while the grant is held, because the memory layer then owns the bit stream. A bit offered on `tx_bit` stays unchanged until the transceiver accepts it. A bus-reset pulse restarts the layer from any state.

Top module: `rom_cmd_layer`

## Requirements
- R1: After `rst_n` is released, `mem_grant` is 0, `overdrive` is 0, `tx_valid` is 0 and `rx_ready` is 1. Bits received before the first bus reset are consumed and discarded, and they never raise the grant.
- R2: After a bus reset, the next 8 accepted bits form the command byte, with the first bit as bit 0. `rx_ready` is 0 whenever `tx_valid` is 1 or `mem_grant` is 1.
- R3: Code 0x33 sends the 64 identity bits on the transmit handshake, bit 0 first. `tx_bit` holds while `tx_valid` is high and `tx_ready` is low. The cycle after the 64th bit is accepted, `mem_grant` is 1.
- R4: Code 0x55 compares 64 received bits, bit 0 first, with the identity. If all of them match, `mem_grant` rises after the last one. The first mismatch sends the layer idle, and there it stays without a grant until the next bus reset.
- R5: Code 0xF0 runs 64 search rounds. In each round the layer sends the identity bit, then sends its complement, then receives a direction bit. A direction equal to the identity bit continues the search. Any other direction makes the layer idle, with `tx_valid` held low. Completing all rounds raises the grant.
- R6: Code 0xEC behaves like 0xF0 when `alarm_in` is 1 at the last bit of the command. Otherwise the layer goes idle, with no transmission and no grant.
- R7: Code 0xCC raises `mem_grant` the cycle after the last command bit.
- R8: Codes 0x3C and 0x69 behave like 0xCC and 0x55 respectively. They also set `overdrive` at the last command bit, whatever the outcome of the compare.
- R9: A successful match or search (0x55, 0x69, 0xF0 or 0xEC) sets a selection flag. Any other command byte except 0xA5 clears it. Code 0xA5 raises the grant only while the flag is set, and otherwise goes idle.
- R10: Any code outside the eight listed goes idle, with no grant and no transmission.
- R11: `bus_rst` aborts any stage, drops `mem_grant` on the next cycle and starts a new command byte. With `rst_std` at 1 it clears `overdrive`. With `rst_std` at 0, `overdrive` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse when a bus reset is detected |
| rst_std | input | 1 | Qualifies `bus_rst`: the reset pulse had standard length |
| rx_valid | input | 1 | Received bit is present |
| rx_bit | input | 1 | Received bit value |
| rx_ready | output | 1 | Layer accepts a received bit this cycle |
| tx_valid | output | 1 | Layer offers a bit to send |
| tx_bit | output | 1 | Bit to send |
| tx_ready | input | 1 | Transceiver takes the offered bit |
| dev_id | input | 64 | Device identity |
| alarm_in | input | 1 | Alarm condition for the conditional search |
| overdrive | output | 1 | Speed flag, 1 = overdrive |
| mem_grant | output | 1 | Memory-function layer may run |

## Verification
Identities are drawn at random, and the match and search commands are driven both with a fully correct bit stream and with one wrong bit at a random position. This separates a compare that checks every bit from one that checks only some, and it shows whether the layer really stops and stays idle after a miss. Read is driven with random back-pressure stalls, which exposes bit order, off-by-one counts and a transmit bit that changes while it waits. Speed is tested with mixed standard and short bus resets, which separates a reset that clears the overdrive flag from one that wrongly keeps it, or the reverse. Resume is run after both successful and failed selections, which catches a selection flag that is never set or never cleared.

// File: rtl/rcl_pkg.sv
package rcl_pkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CODE_READ   = 8'h33;
  localparam logic [CMD_W-1:0] CODE_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] CODE_SEARCH = 8'hF0;
  localparam logic [CMD_W-1:0] CODE_CSRCH  = 8'hEC;
  localparam logic [CMD_W-1:0] CODE_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] CODE_FSKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] CODE_FMATCH = 8'h69;
  localparam logic [CMD_W-1:0] CODE_RESUME = 8'hA5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_SEND_ID, ST_MATCH,
    ST_SR_TRUE, ST_SR_CMPL, ST_SR_DIR, ST_GRANT
  } rcl_state_e;

  typedef enum logic [2:0] {
    OP_READ, OP_MATCH, OP_SEARCH, OP_CSEARCH,
    OP_SKIP, OP_RESUME, OP_UNKNOWN
  } rcl_op_e;

  typedef struct packed {
    rcl_op_e op;
    logic    go_fast;
  } rcl_cmd_t;

endpackage

// File: rtl/rcl_cmd_shift.sv
module rcl_cmd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic         byte_done,
  output logic [W-1:0] byte_out
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  // Byte as it stands once the current bit lands (LSB first).
  assign byte_out  = {bit_in, sh_q[W-1:1]};
  assign byte_done = shift_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q  <= byte_out;
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: the bit counter moves only when a bit is shifted or cleared
  a_r2_cnt_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/rcl_cmd_decode.sv
module rcl_cmd_decode
  import rcl_pkg::*;
(
  input  logic [CMD_W-1:0] code,
  output rcl_cmd_t         cmd
);
  always_comb begin
    cmd.go_fast = 1'b0;
    cmd.op      = OP_UNKNOWN;
    case (code)
      CODE_READ:   cmd.op = OP_READ;
      CODE_MATCH:  cmd.op = OP_MATCH;
      CODE_FMATCH: begin cmd.op = OP_MATCH; cmd.go_fast = 1'b1; end
      CODE_SEARCH: cmd.op = OP_SEARCH;
      CODE_CSRCH:  cmd.op = OP_CSEARCH;
      CODE_SKIP:   cmd.op = OP_SKIP;
      CODE_FSKIP:  begin cmd.op = OP_SKIP; cmd.go_fast = 1'b1; end
      CODE_RESUME: cmd.op = OP_RESUME;
      default:     cmd.op = OP_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/rcl_bit_index.sv
module rcl_bit_index #(
  parameter int N = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  output logic [$clog2(N)-1:0] idx,
  output logic                 last
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] TOP = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clear)  idx <= '0;
    else if (step)   idx <= (idx == TOP) ? '0 : idx + 1'b1;
  end

  assign last = (idx == TOP);

  // R3: the index holds between steps
  a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(idx));

endmodule

// File: rtl/rom_cmd_layer.sv
module rom_cmd_layer
  import rcl_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_rst,
  input  logic            rst_std,
  input  logic            rx_valid,
  input  logic            rx_bit,
  output logic            rx_ready,
  output logic            tx_valid,
  output logic            tx_bit,
  input  logic            tx_ready,
  input  logic [ID_W-1:0] dev_id,
  input  logic            alarm_in,
  output logic            overdrive,
  output logic            mem_grant
);
  localparam int IW = $clog2(ID_W);

  rcl_state_e       state_q;
  logic             sel_q;
  logic             od_q;
  logic             rx_fire, tx_fire;
  logic             byte_done;
  logic [CMD_W-1:0] code;
  rcl_cmd_t         cmd;
  logic [IW-1:0]    idx;
  logic             idx_last;
  logic             idx_clr, idx_step;
  logic             id_bit, bit_ok;

  assign rx_ready = (state_q == ST_IDLE) || (state_q == ST_CMD) ||
                    (state_q == ST_MATCH) || (state_q == ST_SR_DIR);
  assign tx_valid = (state_q == ST_SEND_ID) || (state_q == ST_SR_TRUE) ||
                    (state_q == ST_SR_CMPL);
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;

  assign id_bit = dev_id[idx];
  assign bit_ok = (rx_bit == id_bit);
  assign tx_bit = (state_q == ST_SR_CMPL) ? ~id_bit : (tx_valid & id_bit);

  rcl_cmd_shift #(.W(CMD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (bus_rst || (state_q != ST_CMD)),
    .shift_en (!bus_rst && (state_q == ST_CMD) && rx_fire),
    .bit_in   (rx_bit),
    .byte_done(byte_done),
    .byte_out (code)
  );

  rcl_cmd_decode u_dec (
    .code(code),
    .cmd (cmd)
  );

  assign idx_clr  = bus_rst || (state_q == ST_CMD);
  assign idx_step = ((state_q == ST_SEND_ID) && tx_fire) ||
                    ((state_q == ST_MATCH)   && rx_fire && bit_ok) ||
                    ((state_q == ST_SR_DIR)  && rx_fire && bit_ok);

  rcl_bit_index #(.N(ID_W)) u_idx (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(idx_clr),
    .step (idx_step),
    .idx  (idx),
    .last (idx_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      od_q    <= 1'b0;
    end else if (bus_rst) begin
      state_q <= ST_CMD;
      if (rst_std) od_q <= 1'b0;
    end else begin
      case (state_q)
        ST_CMD: if (byte_done) begin
          if (cmd.go_fast) od_q <= 1'b1;
          if (cmd.op != OP_RESUME) sel_q <= 1'b0;
          case (cmd.op)
            OP_READ:    state_q <= ST_SEND_ID;
            OP_MATCH:   state_q <= ST_MATCH;
            OP_SEARCH:  state_q <= ST_SR_TRUE;
            OP_CSEARCH: state_q <= alarm_in ? ST_SR_TRUE : ST_IDLE;
            OP_SKIP:    state_q <= ST_GRANT;
            OP_RESUME:  state_q <= sel_q ? ST_GRANT : ST_IDLE;
            default:    state_q <= ST_IDLE;
          endcase
        end
        ST_SEND_ID: if (tx_fire && idx_last) state_q <= ST_GRANT;
        ST_MATCH: if (rx_fire) begin
          if (!bit_ok) state_q <= ST_IDLE;
          else if (idx_last) begin
            state_q <= ST_GRANT;
            sel_q   <= 1'b1;
          end
        end
        ST_SR_TRUE: if (tx_fire) state_q <= ST_SR_CMPL;
        ST_SR_CMPL: if (tx_fire) state_q <= ST_SR_DIR;
        ST_SR_DIR: if (rx_fire) begin
          if (!bit_ok) state_q <= ST_IDLE;
          else if (idx_last) begin
            state_q <= ST_GRANT;
            sel_q   <= 1'b1;
          end else state_q <= ST_SR_TRUE;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign overdrive = od_q;
  assign mem_grant = (state_q == ST_GRANT);

  // R2: never receive and transmit at once
  a_r2_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  // R3: an offered bit holds until taken
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_rst) |=> (tx_valid && $stable(tx_bit)));

  // R11: bus reset drops the grant
  a_r11_rst_drop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !mem_grant);

  // R11: a standard-length bus reset returns to standard speed
  a_r11_std_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && rst_std) |=> !overdrive);

  // R8: overdrive is entered only on a completed command byte
  a_r8_fast_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdrive) |-> $past(byte_done && !bus_rst));

  // R9: resume grants only with the selection flag set
  a_r9_resume_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !bus_rst && cmd.op == OP_RESUME) |=> (mem_grant == $past(sel_q)));

  // R4: the grant is reached only from an active stage
  a_r4_grant_path: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_grant) |-> $past(state_q != ST_IDLE));

endmodule

// File: tb/tb_rom_cmd_layer.sv
module tb_rom_cmd_layer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0, rst_std = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, tx_ready = 1'b0;
  logic [63:0] dev_id = 64'h0123_4567_89AB_CDEF;
  logic alarm_in = 1'b0;
  logic rx_ready, tx_valid, tx_bit, overdrive, mem_grant;

  int n_chk = 0, n_bad = 0;
  logic sel_m = 1'b0, od_m = 1'b0;

  always #5 clk = ~clk;

  rom_cmd_layer dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rst_std(rst_std),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .dev_id(dev_id), .alarm_in(alarm_in),
    .overdrive(overdrive), .mem_grant(mem_grant)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_known(input logic [7:0] c);
    return c inside {8'h33, 8'h55, 8'hF0, 8'hEC, 8'hCC, 8'h3C, 8'h69, 8'hA5};
  endfunction

  task automatic pulse_rst(input logic std);
    bus_rst = 1'b1; rst_std = std;
    @(posedge clk); @(negedge clk);
    bus_rst = 1'b0; rst_std = 1'b0;
    if (std) od_m = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    int w;
    w = 0;
    rx_valid = 1'b1; rx_bit = b;
    while (!rx_ready && w < 20) begin @(negedge clk); w++; end
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] c);
    for (int i = 0; i < 8; i++) send_bit(c[i]);
  endtask

  task automatic recv_bit(output logic b);
    int w;
    int stall;
    logic first;
    w = 0;
    while (!tx_valid && w < 20) begin @(negedge clk); w++; end
    first = tx_bit;
    stall = $urandom_range(0, 2);
    for (int k = 0; k < stall; k++) @(negedge clk);
    if (tx_bit !== first) chk("R3 hold", tx_bit, first);
    tx_ready = 1'b1; b = tx_bit;
    @(posedge clk); @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic do_read();
    logic [63:0] got;
    logic b;
    send_byte(8'h33); sel_m = 1'b0;
    for (int i = 0; i < 64; i++) begin recv_bit(b); got[i] = b; end
    chk("R3 id bits", got, dev_id);
    chk("R3 grant", mem_grant, 1);
    chk("R2 rx_ready low in grant", rx_ready, 0);
  endtask

  task automatic do_match(input logic fast, input int bad_pos);
    send_byte(fast ? 8'h69 : 8'h55); sel_m = 1'b0;
    if (fast) begin od_m = 1'b1; chk("R8 speed after match code", overdrive, 1); end
    for (int i = 0; i < 64; i++) send_bit(dev_id[i] ^ (i == bad_pos));
    if (bad_pos < 0) sel_m = 1'b1;
    chk("R4 match grant", mem_grant, (bad_pos < 0));
  endtask

  task automatic do_search(input logic cond, input logic alarm, input int bad_pos);
    logic t, c, ok;
    ok = 1'b1;
    alarm_in = alarm;
    send_byte(cond ? 8'hEC : 8'hF0); sel_m = 1'b0;
    if (cond && !alarm) begin
      chk("R6 no alarm no tx", tx_valid, 0);
      chk("R6 no alarm no grant", mem_grant, 0);
      return;
    end
    for (int i = 0; i < 64; i++) begin
      recv_bit(t); recv_bit(c);
      if (t !== dev_id[i] || c !== ~dev_id[i]) ok = 1'b0;
      if (i == bad_pos) begin
        send_bit(~dev_id[i]);
        chk("R5 lost search idle", tx_valid, 0);
        break;
      end
      send_bit(dev_id[i]);
    end
    chk("R5 search bit pairs", ok, 1);
    if (bad_pos < 0) sel_m = 1'b1;
    chk("R5 search grant", mem_grant, (bad_pos < 0));
  endtask

  task automatic do_skip(input logic fast);
    send_byte(fast ? 8'h3C : 8'hCC); sel_m = 1'b0;
    if (fast) od_m = 1'b1;
    chk("R7 skip grant", mem_grant, 1);
    chk("R8 speed", overdrive, od_m);
  endtask

  task automatic do_resume();
    send_byte(8'hA5);
    chk("R9 resume grant", mem_grant, sel_m);
  endtask

  task automatic do_unknown();
    logic [7:0] c;
    c = 8'(($urandom));
    while (is_known(c)) c = 8'(($urandom));
    send_byte(c); sel_m = 1'b0;
    chk("R10 unknown no grant", mem_grant, 0);
    chk("R10 unknown no tx", tx_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic b;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 grant", mem_grant, 0);
    chk("R1 speed", overdrive, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_ready", rx_ready, 1);
    send_byte(8'hCC);
    chk("R1 no grant before bus reset", mem_grant, 0);

    // R2/R3 read with stalls
    pulse_rst(1'b1);
    chk("R11 new command accepts bits", rx_ready, 1);
    do_read();

    // R11 reset mid-read, then skip
    pulse_rst(1'b1);
    send_byte(8'h33);
    for (int i = 0; i < 10; i++) recv_bit(b);
    pulse_rst(1'b1);
    chk("R11 grant dropped", mem_grant, 0);
    do_skip(1'b0);

    // R8/R11 overdrive kept by short reset, cleared by standard one
    pulse_rst(1'b1);
    do_skip(1'b1);
    pulse_rst(1'b0);
    chk("R11 short reset keeps speed", overdrive, 1);
    pulse_rst(1'b1);
    chk("R11 std reset clears speed", overdrive, 0);

    // R9 resume after failed and good match
    do_match(1'b0, 5);
    pulse_rst(1'b1); do_resume();
    pulse_rst(1'b1); do_match(1'b1, -1);
    pulse_rst(1'b0); do_resume();
    pulse_rst(1'b1); do_unknown();
    pulse_rst(1'b1); do_resume();
    // R4 mismatch on last bit
    pulse_rst(1'b1); do_match(1'b0, 63);
    // R6 alarm low and high
    pulse_rst(1'b1); do_search(1'b1, 1'b0, -1);
    pulse_rst(1'b1); do_search(1'b1, 1'b1, -1);

    for (int it = 0; it < 28; it++) begin
      dev_id = {$urandom, $urandom};
      pulse_rst(1'($urandom_range(0, 1)));
      chk("R11 speed after reset", overdrive, od_m);
      case ($urandom_range(0, 7))
        0: do_read();
        1: do_match(1'($urandom_range(0, 1)), ($urandom_range(0, 1) != 0) ? -1 : int'($urandom_range(0, 63)));
        2: do_search(1'b0, 1'b0, ($urandom_range(0, 1) != 0) ? -1 : int'($urandom_range(0, 63)));
        3: do_search(1'b1, 1'($urandom_range(0, 1)), -1);
        4: do_skip(1'($urandom_range(0, 1)));
        5: do_resume();
        6: do_unknown();
        default: do_resume();
      endcase
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule